// File: doc/BRIEF.md
# IOMMU Control and Fault Register Block

This block is the software-visible face of a small address-translation unit placed in front of a video codec. A host writes a 32-bit word port to load the base address of the top-level pointer table, to switch translation on or off, to arm out-of-range checking and to let faults raise an interrupt. The block presents these settings to the translation walker as plain output signals. It also drives a single-cycle TLB invalidation pulse whenever the host sets the flush bit.

In the other direction, the walker reports faults with a valid strobe, a three-bit cause vector and the offending I/O virtual address. The block collects the causes into sticky status bits and keeps the address of the first fault until software clears the status. While any cause is pending and fault reporting is armed, it holds a level interrupt high. One offset serves two purposes: a write to it arms fault reporting, and a read from it returns the captured fault address.

All storage uses a synchronous active-high reset. Every output, including read data, comes straight from a flop.

Top module: `mmu_regfile`

## Requirements
- R1: After reset, every output is zero and every readable offset returns zero.
- R2: Offset 0x388 is the translation switch. A write copies wdata bit 0 into `xlat_en`, and a read returns it in bit 0 with all other bits zero.
- R3: Offset 0x38C holds the 32-bit pointer-table base. A write takes all 32 bits, which drive `tbl_base` and read back unchanged.
- R4: Offset 0x1AC keeps only bit 28, which drives `oob_check_en`. A read returns that bit in position 28 and zero elsewhere.
- R5: A write to offset 0x380 copies wdata bit 0 into the fault-report enable. A read of 0x380 returns the captured fault address, never the enable.
- R6: Offset 0x384 reads back the cause bits in [2:0] and zero above them. A walker fault ORs its cause vector into these bits, and they stay set until software clears them.
- R7: A write to 0x384 whose bits [2:0] are all zero clears every cause bit. Any other write to 0x384 changes nothing. When a fault arrives in the same cycle as a clearing write, its causes remain set afterwards and its address is captured.
- R8: The fault address is captured only when no cause bit is pending once the same-cycle clear has been applied, so the first fault's address is kept. A fault strobe with an all-zero cause vector changes neither the status nor the address.
- R9: Offset 0x184 stores bit 4 and reads it back in bit 4. `tlb_flush` is high for exactly the one cycle after a write that takes the stored bit from 0 to 1. A write that leaves the bit at 1, or writes 0, gives no pulse.
- R10: `irq` is high exactly when at least one cause bit is set and fault reporting is enabled. It follows the same edge that updates those bits.
- R11: Read data is registered. It shows the value of the offset presented one clock earlier, and any offset other than the six above returns zero.
- R12: Register writes and walker faults take effect at the clock edge that samples them, and the outputs show the new values directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| fault_valid | input | 1 | Walker reports a fault this cycle |
| fault_cause | input | NCAUSE | Cause vector of the reported fault |
| fault_iova | input | 32 | Virtual address that faulted |
| xlat_en | output | 1 | Translation enabled |
| tbl_base | output | 32 | Pointer-table base address |
| oob_check_en | output | 1 | Out-of-range checking enabled |
| tlb_flush | output | 1 | One-cycle TLB invalidation pulse |
| irq | output | 1 | Level fault interrupt |

## Verification
The two functions that can meet in one cycle are a host write of zero to the status offset and a walker fault strobe. The bench provokes this by driving both in the same cycle while an earlier cause is still pending. It then judges the result by reading back the status and the fault address. The status must hold only the new cause, and the address must be the new fault's address, because the clear is applied first and the fault then finds nothing pending. The bench also sweeps every cause vector with fault reporting both armed and disarmed, walks single bits through each writable offset, and reads all 4096 byte offsets against a bench model.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int DATA_W = 32;

  localparam int OFF_FLUSH  = 32'h184;
  localparam int OFF_BOUND  = 32'h1AC;
  localparam int OFF_FAULT  = 32'h380;
  localparam int OFF_STATUS = 32'h384;
  localparam int OFF_CTRL   = 32'h388;
  localparam int OFF_BASE   = 32'h38C;

  localparam int BIT_XLAT_EN = 0;
  localparam int BIT_EXC_EN  = 0;
  localparam int BIT_FLUSH   = 4;
  localparam int BIT_BOUND   = 28;

  typedef struct packed {
    logic ctrl;
    logic base;
    logic bound;
    logic fault;
    logic status;
    logic flush;
  } reg_sel_t;
endpackage

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel        = '0;
    sel.ctrl   = (addr == ADDR_W'(OFF_CTRL));
    sel.base   = (addr == ADDR_W'(OFF_BASE));
    sel.bound  = (addr == ADDR_W'(OFF_BOUND));
    sel.fault  = (addr == ADDR_W'(OFF_FAULT));
    sel.status = (addr == ADDR_W'(OFF_STATUS));
    sel.flush  = (addr == ADDR_W'(OFF_FLUSH));
  end
endmodule

// File: rtl/mmu_cfg_bank.sv
module mmu_cfg_bank
  import mmu_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  reg_sel_t          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              xlat_en,
  output logic [DATA_W-1:0] tbl_base,
  output logic              oob_en,
  output logic              exc_en,
  output logic              exc_en_nxt,
  output logic              flush_bit,
  output logic              tlb_flush
);
  logic flush_rise;

  assign exc_en_nxt = (we && sel.fault) ? wdata[BIT_EXC_EN] : exc_en;
  assign flush_rise = we && sel.flush && wdata[BIT_FLUSH] && !flush_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      xlat_en   <= 1'b0;
      tbl_base  <= '0;
      oob_en    <= 1'b0;
      exc_en    <= 1'b0;
      flush_bit <= 1'b0;
      tlb_flush <= 1'b0;
    end else begin
      if (we && sel.ctrl)  xlat_en   <= wdata[BIT_XLAT_EN];
      if (we && sel.base)  tbl_base  <= wdata;
      if (we && sel.bound) oob_en    <= wdata[BIT_BOUND];
      if (we && sel.flush) flush_bit <= wdata[BIT_FLUSH];
      exc_en    <= exc_en_nxt;
      tlb_flush <= flush_rise;
    end
  end

  // R9: a flush pulse lasts one cycle and leaves the stored bit set
  assert_flush_single_R9: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |=> !tlb_flush);
  assert_flush_bit_set_R9: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> flush_bit);
endmodule

// File: rtl/mmu_fault_trap.sv
module mmu_fault_trap
  import mmu_regs_pkg::*;
#(
  parameter int NCAUSE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fault_valid,
  input  logic [NCAUSE-1:0] fault_cause,
  input  logic [DATA_W-1:0] fault_iova,
  output logic [NCAUSE-1:0] status,
  output logic [NCAUSE-1:0] status_nxt,
  output logic [DATA_W-1:0] fault_addr
);
  logic [NCAUSE-1:0] pending_eff;
  logic              capture;

  assign pending_eff = clr ? '0 : status;
  assign capture     = fault_valid && (|fault_cause) && (pending_eff == '0);

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    assign status_nxt[i] = pending_eff[i] | (fault_valid & fault_cause[i]);

    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= status_nxt[i];
    end

    // R6: a set cause survives any cycle without a clearing write
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (status[i] && !clr) |=> status[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)          fault_addr <= '0;
    else if (capture) fault_addr <= fault_iova;
  end

  // R8: the first fault's address is kept while anything is pending
  assert_first_kept_R8: assert property (@(posedge clk) disable iff (rst)
    ((|status) && !clr) |=> $stable(fault_addr));
  // R7: a clear with no concurrent fault empties the status
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr && !fault_valid) |=> (status == '0));
endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NCAUSE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fault_valid,
  input  logic [NCAUSE-1:0] fault_cause,
  input  logic [31:0]       fault_iova,
  output logic              xlat_en,
  output logic [31:0]       tbl_base,
  output logic              oob_check_en,
  output logic              tlb_flush,
  output logic              irq
);
  reg_sel_t          sel;
  logic              exc_en;
  logic              exc_en_nxt;
  logic              flush_bit;
  logic              clr;
  logic [NCAUSE-1:0] status;
  logic [NCAUSE-1:0] status_nxt;
  logic [DATA_W-1:0] fault_addr;
  logic [DATA_W-1:0] rd_mux;

  mmu_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  mmu_cfg_bank u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .sel        (sel),
    .wdata      (reg_wdata),
    .xlat_en    (xlat_en),
    .tbl_base   (tbl_base),
    .oob_en     (oob_check_en),
    .exc_en     (exc_en),
    .exc_en_nxt (exc_en_nxt),
    .flush_bit  (flush_bit),
    .tlb_flush  (tlb_flush)
  );

  assign clr = reg_we && sel.status && (reg_wdata[NCAUSE-1:0] == '0);

  mmu_fault_trap #(.NCAUSE(NCAUSE)) u_trap (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .fault_valid (fault_valid),
    .fault_cause (fault_cause),
    .fault_iova  (fault_iova),
    .status      (status),
    .status_nxt  (status_nxt),
    .fault_addr  (fault_addr)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.ctrl)   rd_mux[BIT_XLAT_EN] = xlat_en;
    if (sel.base)   rd_mux = tbl_base;
    if (sel.bound)  rd_mux[BIT_BOUND] = oob_check_en;
    if (sel.fault)  rd_mux = fault_addr;
    if (sel.status) rd_mux[NCAUSE-1:0] = status;
    if (sel.flush)  rd_mux[BIT_FLUSH] = flush_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq       <= (|status_nxt) && exc_en_nxt;
    end
  end

  // R10: interrupt level tracks pending causes gated by the enable
  assert_irq_level_R10: assert property (@(posedge clk) disable iff (rst)
    irq == ((|status) && exc_en));
  // R11: an unmapped offset reads as zero on the following cycle
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $past(sel == '0) |-> (reg_rdata == '0));
  // R1: reset leaves all outputs low
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!irq && !tlb_flush && !xlat_en && !oob_check_en && tbl_base == '0));
endmodule

// File: tb/tb_mmu_regfile.sv
module tb_mmu_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fault_valid = 1'b0;
  logic [2:0]  fault_cause = '0;
  logic [31:0] fault_iova = '0;
  logic        xlat_en, oob_check_en, tlb_flush, irq;
  logic [31:0] tbl_base;

  int errors = 0;
  int checks = 0;

  // bench model of the register state
  logic        m_ctl = 0, m_bound = 0, m_exc = 0, m_flush = 0;
  logic [31:0] m_base = 0, m_faddr = 0;
  logic [2:0]  m_stat = 0;

  always #4 clk = ~clk;

  mmu_regfile dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault_valid(fault_valid),
    .fault_cause(fault_cause), .fault_iova(fault_iova), .xlat_en(xlat_en),
    .tbl_base(tbl_base), .oob_check_en(oob_check_en), .tlb_flush(tlb_flush),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a)
      12'h388: exp_rd = {31'b0, m_ctl};
      12'h38C: exp_rd = m_base;
      12'h1AC: exp_rd = {3'b0, m_bound, 28'b0};
      12'h380: exp_rd = m_faddr;
      12'h384: exp_rd = {29'b0, m_stat};
      12'h184: exp_rd = {27'b0, m_flush, 4'b0};
      default: exp_rd = 32'h0;
    endcase
  endfunction

  // model of one cycle with optional write and optional fault (R12 timing)
  task automatic model_cycle(input logic w, input logic [11:0] a, input logic [31:0] d,
                             input logic f, input logic [2:0] c, input logic [31:0] v);
    logic [2:0] eff;
    eff = m_stat;
    if (w) begin
      case (a)
        12'h388: m_ctl = d[0];
        12'h38C: m_base = d;
        12'h1AC: m_bound = d[28];
        12'h380: m_exc = d[0];
        12'h384: if (d[2:0] == 3'b0) eff = 3'b0;
        12'h184: m_flush = d[4];
        default: ;
      endcase
    end
    if (f && c != 3'b0 && eff == 3'b0) m_faddr = v;
    m_stat = eff | (f ? c : 3'b0);
  endtask

  task automatic cyc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     input logic f, input logic [2:0] c, input logic [31:0] v);
    @(negedge clk);
    reg_we = w; reg_addr = a; reg_wdata = d;
    fault_valid = f; fault_cause = c; fault_iova = v;
    @(negedge clk);
    reg_we = 1'b0; fault_valid = 1'b0;
    model_cycle(w, a, d, f, c, v);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 3'b0, 32'h0);
  endtask

  task automatic flt(input logic [2:0] c, input logic [31:0] v);
    cyc(1'b0, 12'h0, 32'h0, 1'b1, c, v);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp_rd(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 outputs", {27'b0, xlat_en, oob_check_en, tlb_flush, irq, 1'b0}, 32'h0);
    check("R1 tbl_base", tbl_base, 32'h0);
    rd_chk("R1 ctrl", 12'h388); rd_chk("R1 base", 12'h38C);
    rd_chk("R1 bound", 12'h1AC); rd_chk("R1 fault", 12'h380);
    rd_chk("R1 status", 12'h384); rd_chk("R1 flush", 12'h184);

    // R2: translation switch
    pats = '{32'h1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0};
    foreach (pats[k]) begin
      wr(12'h388, pats[k]);
      check("R2 xlat_en", {31'b0, xlat_en}, {31'b0, pats[k][0]});
      rd_chk("R2 readback", 12'h388);
    end

    // R3: table base, walking ones and patterns
    for (int i = 0; i < 32; i++) begin
      wr(12'h38C, 32'h1 << i);
      check("R3 tbl_base", tbl_base, 32'h1 << i);
    end
    wr(12'h38C, 32'hA5A5_5A5A);
    check("R3 tbl_base", tbl_base, 32'hA5A5_5A5A);
    rd_chk("R3 readback", 12'h38C);

    // R4: bound config keeps only bit 28
    for (int i = 0; i < 32; i++) begin
      wr(12'h1AC, 32'h1 << i);
      check("R4 oob_check_en", {31'b0, oob_check_en}, {31'b0, (i == 28)});
      rd_chk("R4 readback", 12'h1AC);
    end

    // R9: flush pulse on 0->1 only
    wr(12'h184, 32'h10);
    check("R9 pulse", {31'b0, tlb_flush}, 32'h1);
    @(negedge clk);
    check("R9 pulse ends", {31'b0, tlb_flush}, 32'h0);
    rd_chk("R9 readback", 12'h184);
    wr(12'h184, 32'h10);
    check("R9 no pulse when already set", {31'b0, tlb_flush}, 32'h0);
    wr(12'h184, 32'h0);
    check("R9 no pulse on zero", {31'b0, tlb_flush}, 32'h0);
    wr(12'h184, 32'hFFFF_FFEF);
    check("R9 no pulse bit4 clear", {31'b0, tlb_flush}, 32'h0);
    wr(12'h184, 32'h10);
    check("R9 pulse again", {31'b0, tlb_flush}, 32'h1);

    // R5 R6 R8 R10: all cause vectors, reporting armed and disarmed
    for (int e = 0; e < 2; e++) begin
      wr(12'h380, e[31:0]);
      rd_chk("R5 read returns address not enable", 12'h380);
      for (int c = 0; c < 8; c++) begin
        flt(c[2:0], 32'h1000 * c + 32'h123 + e);
        rd_chk("R6 status", 12'h384);
        rd_chk("R8 capture", 12'h380);
        check("R10 irq", {31'b0, irq}, {31'b0, (m_exc && m_stat != 0)});
        flt(3'b111 ^ c[2:0], 32'hDEAD_0000 + c);
        rd_chk("R8 first kept", 12'h380);
        rd_chk("R6 sticky or", 12'h384);
        wr(12'h384, 32'h4);
        rd_chk("R7 nonzero write ignored", 12'h384);
        wr(12'h384, 32'hFFFF_FFF8);
        rd_chk("R7 clear", 12'h384);
        check("R10 irq after clear", {31'b0, irq}, 32'h0);
      end
    end

    // R7: clear and fault in the same cycle
    flt(3'b001, 32'h0000_AAAA);
    cyc(1'b1, 12'h384, 32'h0, 1'b1, 3'b100, 32'h0000_BBBB);
    rd_chk("R7 concurrent status", 12'h384);
    check("R7 concurrent status value", {29'b0, m_stat}, 32'h4);
    rd_chk("R7 concurrent addr", 12'h380);
    check("R7 concurrent addr value", m_faddr, 32'h0000_BBBB);

    // R10: enable toggling with a pending cause
    wr(12'h380, 32'h0);
    check("R10 disarmed", {31'b0, irq}, 32'h0);
    wr(12'h380, 32'h1);
    check("R10 armed", {31'b0, irq}, 32'h1);

    // R11: every byte offset against the model
    wr(12'h388, 32'h1);
    wr(12'h1AC, 32'h1000_0000);
    wr(12'h38C, 32'h1234_5678);
    for (int a = 0; a < 4096; a++) rd_chk("R11 read sweep", a[11:0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule